// File: doc/BRIEF.md
# One-Time-Programmable Memory Command Front End

This block places a small set of 32-bit registers in front of a one-time-programmable word array. Software first loads a target word address into the address register. It then writes a 32-bit key word to the command register. Three exact key values start an operation: a fetch, a mode-set, or a burn. Any other value starts an operation that fails. The block models the fuse array internally as a word-addressed store of `ARRAY_WORDS` entries.

A fetch returns its result in two data registers. The second data register is filled only when the address lies in the lower data region. A burn copies the first data register into the array. Each command runs for a fixed `CMD_LAT` cycles, and both idle flags in the status register stay low for that whole time. A sticky fault flag records whether the most recent command failed.

Register offsets (byte addresses) are: 0x000 protection, 0x004 command, 0x010 address, 0x014 status, 0x020 data word 1, 0x024 data word 2 and 0x040 configuration. Reads are registered, so `bus_rdata` holds the addressed value from the cycle after `bus_re` is sampled. Address bits 1:0 are ignored. The asynchronous reset is released through a two-stage synchronizer.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: After reset, protection, address and both data registers read 0. Status reads 0x6: bit 1 is the memory-idle flag, bit 2 is the controller-idle flag, and bit 4 is the fault flag, which is clear. Configuration reads `RSA_MODE` in bits 13:12 and `HASH_MODE` in bits 11:10, which is 0x2400 with the defaults.
- R2: The protection (0x000), address (0x010), data word 1 (0x020) and data word 2 (0x024) registers return the last value written by the bus. The one exception is when a completing command loads them.
- R3: Bus writes to status (0x014) and configuration (0x040) are dropped. The command register (0x004) always reads 0.
- R4: Offsets that have no register read 0, whether they lie inside the `REG_WORDS` window or beyond it. Writes to such offsets change no register.
- R5: A command write accepted while idle clears status bits 1 and 2 for exactly `CMD_LAT` cycles. After that both bits are set again, whatever the outcome of the command.
- R6: A command register write that arrives while a command is running is ignored. The running command keeps the address and data word 1 value that it captured when it was accepted.
- R7: Key 0x23B1E364 stores the data word 1 value, as captured at acceptance, into the array word at the captured address. Addresses of `ARRAY_WORDS` (0x1000) and above store nothing and set the fault flag.
- R8: Key 0x23B1E361 with an address below `DATA_WORDS` (0x800) loads word[a] into data word 1 and word[a+1] into data word 2.
- R9: Key 0x23B1E361 with an address from 0x800 to 0xFFF loads only data word 1, and data word 2 is unchanged. With an address of 0x1000 or above it loads neither data register and sets the fault flag.
- R10: Key 0x23B1E362 with address 0, 0x1000, 0x3000 or 0x5000 completes with no fault and no data change. Any other address sets the fault flag.
- R11: Any other command word still runs the busy period. It sets the fault flag and changes no data register.
- R12: The fault flag (status bit 4) is set when a failing command completes. It is cleared in the cycle after the next command is accepted, so it is already 0 while that command is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | BUS_AW | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The hardest situation to reach from the ports is a second command register write that lands inside the busy window of a burn. The same case applies to address and data writes that land inside that window. The bench writes a burn key and then issues an address write, a data write and a further burn key on the three following cycles. It then fetches both the original and the altered address. This shows that only the value captured at acceptance reached the array. The bench also reads status back to back, one cycle apart, right after acceptance to measure the exact width of the idle-low window.

// File: rtl/otp_cmd_pkg.sv
package otp_cmd_pkg;

  // Word indices of the implemented registers (byte offset / 4)
  localparam int unsigned IDX_PROT = 0;
  localparam int unsigned IDX_CMD  = 1;
  localparam int unsigned IDX_ADDR = 4;
  localparam int unsigned IDX_STAT = 5;
  localparam int unsigned IDX_DAT1 = 8;
  localparam int unsigned IDX_DAT2 = 9;
  localparam int unsigned IDX_CFG  = 16;

  // Command keys
  localparam logic [31:0] KEY_FETCH = 32'h23B1_E361;
  localparam logic [31:0] KEY_MODE  = 32'h23B1_E362;
  localparam logic [31:0] KEY_BURN  = 32'h23B1_E364;

  // Accepted mode-set addresses besides zero
  localparam logic [31:0] MODE_ADR0 = 32'h0000_1000;
  localparam logic [31:0] MODE_ADR1 = 32'h0000_3000;
  localparam logic [31:0] MODE_ADR2 = 32'h0000_5000;

  // Status bit positions
  localparam int unsigned STB_MEM_IDLE = 1;
  localparam int unsigned STB_CTL_IDLE = 2;
  localparam int unsigned STB_FAULT    = 4;

  // Configuration field positions
  localparam int unsigned CFB_RSA  = 12;
  localparam int unsigned CFB_HASH = 10;

  typedef enum logic [1:0] {
    OP_BAD   = 2'd0,
    OP_FETCH = 2'd1,
    OP_MODE  = 2'd2,
    OP_BURN  = 2'd3
  } op_e;

endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int unsigned WORDS = 4096,
  parameter int unsigned AW    = $clog2(WORDS),
  parameter int unsigned NRD   = 2
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [31:0]              wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][31:0]     rdata
);

  logic [31:0] mem [WORDS];

  // Storage array: written only under its enable, no reset
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end

endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
  import otp_cmd_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  input  logic [31:0] addr_word,
  input  logic [31:0] data_word,
  output logic        busy,
  output logic        accept,
  output logic        fin,
  output op_e         op,
  output logic [31:0] op_addr,
  output logic [31:0] op_data
);

  localparam int unsigned CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] CNT_START = CW'(LAT - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  op_e           op_q, op_d;
  logic [31:0]   addr_q, addr_d;
  logic [31:0]   data_q, data_d;

  function automatic op_e classify(input logic [31:0] w);
    op_e r;
    case (w)
      KEY_FETCH: r = OP_FETCH;
      KEY_MODE:  r = OP_MODE;
      KEY_BURN:  r = OP_BURN;
      default:   r = OP_BAD;
    endcase
    return r;
  endfunction

  always_comb begin
    accept = cmd_wr && !busy_q;
    fin    = busy_q && (cnt_q == '0);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    addr_d = addr_q;
    data_d = data_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNT_START;
      op_d   = classify(cmd_word);
      addr_d = addr_word;
      data_d = data_word;
    end else if (fin) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_BAD;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign busy    = busy_q;
  assign op      = op_q;
  assign op_addr = addr_q;
  assign op_data = data_q;

  // R5
  busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (cnt_q != '0) |=> busy_q);

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && busy_q |=> $stable(addr_q) && $stable(op_q) && $stable(data_q));

endmodule

// File: rtl/otp_op_resolve.sv
module otp_op_resolve
  import otp_cmd_pkg::*;
#(
  parameter int unsigned WORDS      = 4096,
  parameter int unsigned DATA_WORDS = 2048,
  parameter int unsigned AW         = $clog2(WORDS)
) (
  input  logic          fin,
  input  op_e           op,
  input  logic [31:0]   op_addr,
  input  logic [31:0]   op_data,
  input  logic [31:0]   rd_lo,
  input  logic [31:0]   rd_hi,
  output logic [AW-1:0] raddr_lo,
  output logic [AW-1:0] raddr_hi,
  output logic          arr_we,
  output logic [AW-1:0] arr_waddr,
  output logic [31:0]   arr_wdata,
  output logic          ld_lo,
  output logic          ld_hi,
  output logic [31:0]   ld_lo_val,
  output logic [31:0]   ld_hi_val,
  output logic          err_set
);

  logic in_arr, in_dat, mode_ok;

  always_comb begin
    in_arr    = op_addr < 32'(WORDS);
    in_dat    = op_addr < 32'(DATA_WORDS);
    mode_ok   = (op_addr == '0) || (op_addr == MODE_ADR0) ||
                (op_addr == MODE_ADR1) || (op_addr == MODE_ADR2);
    raddr_lo  = op_addr[AW-1:0];
    raddr_hi  = op_addr[AW-1:0] + AW'(1);
    arr_waddr = op_addr[AW-1:0];
    arr_wdata = op_data;
    ld_lo_val = rd_lo;
    ld_hi_val = rd_hi;
    arr_we    = 1'b0;
    ld_lo     = 1'b0;
    ld_hi     = 1'b0;
    err_set   = 1'b0;
    case (op)
      OP_FETCH: begin
        ld_lo   = fin && in_arr;
        ld_hi   = fin && in_dat;
        err_set = fin && !in_arr;
      end
      OP_MODE: begin
        err_set = fin && !mode_ok;
      end
      OP_BURN: begin
        arr_we  = fin && in_arr;
        err_set = fin && !in_arr;
      end
      default: begin
        err_set = fin;
      end
    endcase
  end

endmodule

// File: rtl/otp_reg_bank.sv
module otp_reg_bank
  import otp_cmd_pkg::*;
#(
  parameter int unsigned BUS_AW    = 12,
  parameter int unsigned REG_WORDS = 32,
  parameter logic [1:0]  RSA_MODE  = 2'b10,
  parameter logic [1:0]  HASH_MODE = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic              cmd_accept,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [31:0]       ld_lo_val,
  input  logic [31:0]       ld_hi_val,
  input  logic              err_set,
  output logic              cmd_wr,
  output logic [31:0]       addr_q,
  output logic [31:0]       dat1_q
);

  localparam int unsigned IW = BUS_AW - 2;

  logic [IW-1:0] idx;
  logic          hit;
  logic [1:0]    unused_lo;
  logic          we_prot, we_addr, we_d1, we_d2;
  logic [31:0]   prot_q, prot_d, addr_d, dat1_d, dat2_q, dat2_d;
  logic          err_q, err_d;
  logic [31:0]   rdata_q, rdata_d;
  logic [31:0]   status_w, cfg_w;

  assign idx       = bus_addr[BUS_AW-1:2];
  assign unused_lo = bus_addr[1:0];
  assign hit       = 32'(idx) < REG_WORDS;

  always_comb begin
    we_prot = bus_we && hit && (idx == IW'(IDX_PROT));
    we_addr = bus_we && hit && (idx == IW'(IDX_ADDR));
    we_d1   = bus_we && hit && (idx == IW'(IDX_DAT1));
    we_d2   = bus_we && hit && (idx == IW'(IDX_DAT2));
    cmd_wr  = bus_we && hit && (idx == IW'(IDX_CMD));
  end

  always_comb begin
    status_w = '0;
    status_w[STB_MEM_IDLE] = !busy;
    status_w[STB_CTL_IDLE] = !busy;
    status_w[STB_FAULT]    = err_q;
    cfg_w = '0;
    cfg_w[CFB_RSA +: 2]  = RSA_MODE;
    cfg_w[CFB_HASH +: 2] = HASH_MODE;
  end

  // Next-state: command completion outranks a same-cycle bus write
  always_comb begin
    prot_d = we_prot ? bus_wdata : prot_q;
    addr_d = we_addr ? bus_wdata : addr_q;
    dat1_d = ld_lo ? ld_lo_val : (we_d1 ? bus_wdata : dat1_q);
    dat2_d = ld_hi ? ld_hi_val : (we_d2 ? bus_wdata : dat2_q);
    err_d  = err_q;
    if (cmd_accept) begin
      err_d = 1'b0;
    end else if (err_set) begin
      err_d = 1'b1;
    end
    rdata_d = rdata_q;
    if (bus_re) begin
      rdata_d = '0;
      if (hit) begin
        case (idx)
          IW'(IDX_PROT): rdata_d = prot_q;
          IW'(IDX_ADDR): rdata_d = addr_q;
          IW'(IDX_STAT): rdata_d = status_w;
          IW'(IDX_DAT1): rdata_d = dat1_q;
          IW'(IDX_DAT2): rdata_d = dat2_q;
          IW'(IDX_CFG):  rdata_d = cfg_w;
          default:       rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q  <= '0;
      addr_q  <= '0;
      dat1_q  <= '0;
      dat2_q  <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      prot_q  <= prot_d;
      addr_q  <= addr_d;
      dat1_q  <= dat1_d;
      dat2_q  <= dat2_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  // R12
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !err_q);

  // R2
  dat1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_d1 || ld_lo) |=> $stable(dat1_q));

endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
  import otp_cmd_pkg::*;
#(
  parameter int unsigned ARRAY_WORDS = 4096,
  parameter int unsigned DATA_WORDS  = 2048,
  parameter int unsigned CMD_LAT     = 4,
  parameter int unsigned REG_WORDS   = 32,
  parameter int unsigned BUS_AW      = 12,
  parameter logic [1:0]  RSA_MODE    = 2'b10,
  parameter logic [1:0]  HASH_MODE   = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int unsigned ARR_AW = $clog2(ARRAY_WORDS);
  localparam int unsigned NRD    = 2;

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  logic                       cmd_wr, seq_busy, seq_accept, seq_fin;
  op_e                        seq_op;
  logic [31:0]                seq_addr, seq_data, addr_q, dat1_q;
  logic [ARR_AW-1:0]          raddr_lo, raddr_hi, arr_waddr;
  logic [NRD-1:0][ARR_AW-1:0] arr_raddr;
  logic [NRD-1:0][31:0]       arr_rdata;
  logic                       arr_we, res_ld_lo, res_ld_hi, res_err;
  logic [31:0]                arr_wdata, res_lo_val, res_hi_val;

  assign arr_raddr[0] = raddr_lo;
  assign arr_raddr[1] = raddr_hi;

  otp_reg_bank #(
    .BUS_AW(BUS_AW), .REG_WORDS(REG_WORDS),
    .RSA_MODE(RSA_MODE), .HASH_MODE(HASH_MODE)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(seq_busy), .cmd_accept(seq_accept),
    .ld_lo(res_ld_lo), .ld_hi(res_ld_hi),
    .ld_lo_val(res_lo_val), .ld_hi_val(res_hi_val),
    .err_set(res_err), .cmd_wr(cmd_wr),
    .addr_q(addr_q), .dat1_q(dat1_q)
  );

  otp_cmd_seq #(.LAT(CMD_LAT)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .cmd_wr(cmd_wr), .cmd_word(bus_wdata),
    .addr_word(addr_q), .data_word(dat1_q),
    .busy(seq_busy), .accept(seq_accept), .fin(seq_fin),
    .op(seq_op), .op_addr(seq_addr), .op_data(seq_data)
  );

  otp_op_resolve #(
    .WORDS(ARRAY_WORDS), .DATA_WORDS(DATA_WORDS), .AW(ARR_AW)
  ) u_res (
    .fin(seq_fin), .op(seq_op), .op_addr(seq_addr), .op_data(seq_data),
    .rd_lo(arr_rdata[0]), .rd_hi(arr_rdata[1]),
    .raddr_lo(raddr_lo), .raddr_hi(raddr_hi),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .ld_lo(res_ld_lo), .ld_hi(res_ld_hi),
    .ld_lo_val(res_lo_val), .ld_hi_val(res_hi_val),
    .err_set(res_err)
  );

  otp_fuse_array #(.WORDS(ARRAY_WORDS), .AW(ARR_AW), .NRD(NRD)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );

  // R8
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_ld_lo |=> (dat1_q == $past(res_lo_val)));

endmodule

// File: tb/otp_cmd_ctrl_test.sv
module otp_cmd_ctrl_test;

  localparam int unsigned LAT = 4;
  localparam logic [11:0] A_PROT = 12'h000;
  localparam logic [11:0] A_CMD  = 12'h004;
  localparam logic [11:0] A_ADDR = 12'h010;
  localparam logic [11:0] A_STAT = 12'h014;
  localparam logic [11:0] A_D1   = 12'h020;
  localparam logic [11:0] A_D2   = 12'h024;
  localparam logic [11:0] A_CFG  = 12'h040;
  localparam logic [31:0] K_RD = 32'h23B1_E361;
  localparam logic [31:0] K_WR = 32'h23B1_E362;
  localparam logic [31:0] K_PG = 32'h23B1_E364;
  localparam logic [31:0] ST_IDLE = 32'h6;
  localparam logic [31:0] ST_FLT  = 32'h16;

  logic        clk, rst_n, bus_we, bus_re;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, v;
  int          n_chk, n_fail;
  bit          done;

  otp_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic run(input logic [31:0] key, input logic [31:0] adr);
    wr(A_ADDR, adr);
    wr(A_CMD, key);
    repeat (LAT) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(A_PROT, v); chk("R1 prot", v, 32'h0);
    rd(A_ADDR, v); chk("R1 addr", v, 32'h0);
    rd(A_D1, v);   chk("R1 dat1", v, 32'h0);
    rd(A_D2, v);   chk("R1 dat2", v, 32'h0);
    rd(A_STAT, v); chk("R1 status", v, ST_IDLE);
    rd(A_CFG, v);  chk("R1 cfg", v, 32'h0000_2400);

    // R2 readback
    wr(A_PROT, 32'hA5A5_1234); rd(A_PROT, v); chk("R2 prot", v, 32'hA5A5_1234);
    wr(A_ADDR, 32'h0000_0777); rd(A_ADDR, v); chk("R2 addr", v, 32'h0000_0777);
    wr(A_D1, 32'h1357_9BDF);   rd(A_D1, v);   chk("R2 dat1", v, 32'h1357_9BDF);
    wr(A_D2, 32'h2468_ACE0);   rd(A_D2, v);   chk("R2 dat2", v, 32'h2468_ACE0);

    // R4 holes and out-of-window offsets
    wr(12'h00C, 32'hFFFF_FFFF); rd(12'h00C, v); chk("R4 hole", v, 32'h0);
    wr(12'h080, 32'hFFFF_FFFF); rd(12'h080, v); chk("R4 beyond", v, 32'h0);
    wr(12'hFFC, 32'hFFFF_FFFF); rd(12'hFFC, v); chk("R4 top", v, 32'h0);
    rd(A_PROT, v); chk("R4 prot untouched", v, 32'hA5A5_1234);
    rd(A_D1, v);   chk("R4 dat1 untouched", v, 32'h1357_9BDF);

    // R7 burn sweep over the whole array
    for (int a = 0; a < 4096; a++) begin
      wr(A_D1, pat(a));
      run(K_PG, 32'(a));
    end

    // R8 / R9 fetch sweep
    begin
      logic [31:0] exp2;
      exp2 = 32'h2468_ACE0;
      for (int a = 0; a < 4096; a++) begin
        run(K_RD, 32'(a));
        if (a < 2048) exp2 = pat(a + 1);
        rd(A_D1, v);   chk(a < 2048 ? "R8 lo" : "R9 lo", v, pat(a));
        rd(A_D2, v);   chk(a < 2048 ? "R8 hi" : "R9 hi kept", v, exp2);
        rd(A_STAT, v); chk("R5 idle after fetch", v, ST_IDLE);
      end
    end

    // R9 invalid fetch
    wr(A_D1, 32'h1111_1111); wr(A_D2, 32'h2222_2222);
    run(K_RD, 32'h0000_1000);
    rd(A_D1, v);   chk("R9 bad lo", v, 32'h1111_1111);
    rd(A_D2, v);   chk("R9 bad hi", v, 32'h2222_2222);
    rd(A_STAT, v); chk("R9 fault", v, ST_FLT);

    // R5 window width and R12 clear on next start
    wr(A_ADDR, 32'd5);
    wr(A_CMD, K_RD);
    for (int i = 0; i < LAT; i++) begin
      rd(A_STAT, v); chk("R5 R12 busy status", v, 32'h0);
    end
    rd(A_STAT, v); chk("R5 idle again", v, ST_IDLE);
    rd(A_D1, v);   chk("R8 after window lo", v, pat(5));
    rd(A_D2, v);   chk("R8 after window hi", v, pat(6));

    // R3 read-only and command readback
    wr(A_STAT, 32'hFFFF_FFFF); rd(A_STAT, v); chk("R3 status ro", v, ST_IDLE);
    wr(A_CFG, 32'h0);          rd(A_CFG, v);  chk("R3 cfg ro", v, 32'h0000_2400);
    rd(A_CMD, v); chk("R3 cmd reads zero", v, 32'h0);

    // R10 mode-set addresses
    run(K_WR, 32'h0);         rd(A_STAT, v); chk("R10 addr0", v, ST_IDLE);
    run(K_WR, 32'h1000);      rd(A_STAT, v); chk("R10 1000", v, ST_IDLE);
    run(K_WR, 32'h3000);      rd(A_STAT, v); chk("R10 3000", v, ST_IDLE);
    run(K_WR, 32'h5000);      rd(A_STAT, v); chk("R10 5000", v, ST_IDLE);
    run(K_WR, 32'h2000);      rd(A_STAT, v); chk("R10 2000", v, ST_FLT);
    run(K_WR, 32'h1);         rd(A_STAT, v); chk("R10 0001", v, ST_FLT);
    run(K_WR, 32'h3001);      rd(A_STAT, v); chk("R10 3001", v, ST_FLT);
    rd(A_D1, v); chk("R10 no data change", v, pat(5));

    // R11 unknown keys
    wr(A_ADDR, 32'd7);
    wr(A_CMD, 32'h23B1_E363);
    rd(A_STAT, v); chk("R11 busy on bad key", v, 32'h0);
    repeat (LAT) @(negedge clk);
    rd(A_STAT, v); chk("R11 fault", v, ST_FLT);
    run(32'h23B1_E360, 32'd9);
    rd(A_STAT, v); chk("R11 fault 2", v, ST_FLT);
    rd(A_D1, v);   chk("R11 lo kept", v, pat(5));
    rd(A_D2, v);   chk("R11 hi kept", v, pat(6));

    // R7 burn uses captured data, out-of-range burn faults
    wr(A_D1, 32'hCAFE_F00D);
    run(K_PG, 32'd300);
    rd(A_STAT, v); chk("R7 no fault", v, ST_IDLE);
    run(K_RD, 32'd300);
    rd(A_D1, v); chk("R7 burned", v, 32'hCAFE_F00D);
    rd(A_D2, v); chk("R7 neighbour", v, pat(301));
    wr(A_D1, 32'h0000_DEAD);
    run(K_PG, 32'h1000);
    rd(A_STAT, v); chk("R7 range fault", v, ST_FLT);

    // R6 writes during busy window
    wr(A_D1, 32'h0BAD_BEEF);
    wr(A_ADDR, 32'd400);
    wr(A_CMD, K_PG);
    wr(A_ADDR, 32'd401);
    wr(A_D1, 32'h1234_5678);
    wr(A_CMD, K_PG);
    repeat (LAT) @(negedge clk);
    run(K_RD, 32'd400);
    rd(A_D1, v); chk("R6 captured data", v, 32'h0BAD_BEEF);
    rd(A_D2, v); chk("R6 second burn ignored", v, pat(401));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule